// File: doc/BRIEF.md
# Data Memory Front End with Pointer Indirection

This block is the data-memory side of a small 8-bit controller core. It takes a 6-bit direct address and sorts it into one of several targets: a pointer register, an accumulator, a bank of plain special-function storage, two dead locations, and 32 bytes of general-purpose RAM in the upper half of the map (20H to 3FH). Reads are combinational from the address. Writes land on the next rising clock edge.

Address 00H has no storage of its own. Any access to it is redirected to the location named by the pointer at 01H. The redirected address goes through the same decode as a direct one, so it can reach RAM, the accumulator, other special registers, or the pointer itself. A pointer whose address bits are zero makes the alias refer to itself: reads then return 00H and writes are dropped. The pointer keeps 7 bits, and its top data bit reads as one. The accumulator sits at 05H and is also driven onto a dedicated output, and the pointer has a side output too.

Top module: `dmemFront`

## Requirements
- R1: The 32 RAM bytes at 20H-3FH store what is written. A write with `wrEn` high is visible on `rdData` from the cycle after the write edge, and `rdData` follows `addr` combinationally.
- R2: When `addr` is 00H and pointer bits 5:0 are non-zero, a read or write acts on the location whose address is pointer bits 5:0, using the same decode as a direct access. Pointer bit 6 plays no part in forming the address.
- R3: When `addr` is 00H and pointer bits 5:0 are zero, `rdData` is 00H.
- R4: When `addr` is 00H and pointer bits 5:0 are zero, a write changes no storage: the pointer, the accumulator, the special registers and the RAM all keep their values.
- R5: A write to 01H, made directly or through the alias, stores `wrData[6:0]` into the pointer, and `ptrOut` shows it after the edge.
- R6: A read of 01H returns bit 7 as 1 and bits 6:0 as the pointer.
- R7: The accumulator can be read and written at 05H, and `accOut` always shows its value.
- R8: Addresses 1EH and 1FH read as 00H, and writes to them, whether direct or through the alias, are ignored.
- R9: After reset, the pointer, the accumulator and all the special-function storage at 02H-04H and 06H-1DH read 00H.
- R10: Addresses 02H-04H and 06H-1DH are plain 8-bit read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | Direct data-memory address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe for the addressed location |
| rdData | output | 8 | Read data for `addr`, combinational |
| accOut | output | 8 | Current accumulator value |
| ptrOut | output | 7 | Current pointer value |

## Verification
Read data is due in the same cycle that the address is presented. The bench therefore drives its inputs on the falling edge and samples `rdData` a short delay later, before the next rising edge. A write shows up on `rdData`, `accOut` and `ptrOut` only after the rising edge that follows it. So the reference model applies each write just after that edge, and the comparison in the next cycle sees the new value. Pointer redirection has no pipeline stage, so an aliased access is compared in the same cycle as a direct one.

// File: rtl/dmemPkg.sv
package dmemPkg;
  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_PTR,
    SEL_ACC,
    SEL_SFR,
    SEL_RAM
  } selKindT;

  typedef struct packed {
    logic    wrPtr;
    logic    wrAcc;
    logic    wrSfr;
    logic    wrRam;
    selKindT sel;
  } ctrlStrobesT;
endpackage

// File: rtl/dmemCtrl.sv
module dmemCtrl
  import dmemPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int ACC_ADDR = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] ptrLow,
  output ctrlStrobesT       strobes,
  output logic [ADDR_W-2:0] effIdx
);
  localparam logic [ADDR_W-1:0] ALIAS_A  = '0;
  localparam logic [ADDR_W-1:0] PTR_A    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ACC_A    = ADDR_W'(ACC_ADDR);
  localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(2 ** (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] DEAD_LO  = RAM_BASE - ADDR_W'(2);

  logic [ADDR_W-1:0] effAddr;
  selKindT           sel;

  // Redirect the alias through the pointer, then decode one address.
  assign effAddr = (addr == ALIAS_A) ? ptrLow : addr;
  assign effIdx  = effAddr[ADDR_W-2:0];

  always_comb begin
    if (effAddr == ALIAS_A)       sel = SEL_ZERO;
    else if (effAddr == PTR_A)    sel = SEL_PTR;
    else if (effAddr == ACC_A)    sel = SEL_ACC;
    else if (effAddr >= RAM_BASE) sel = SEL_RAM;
    else if (effAddr >= DEAD_LO)  sel = SEL_ZERO;
    else                          sel = SEL_SFR;
  end

  always_comb begin
    strobes.sel   = sel;
    strobes.wrPtr = wrEn && (sel == SEL_PTR);
    strobes.wrAcc = wrEn && (sel == SEL_ACC);
    strobes.wrSfr = wrEn && (sel == SEL_SFR);
    strobes.wrRam = wrEn && (sel == SEL_RAM);
  end
endmodule

// File: rtl/dmemData.sv
module dmemData
  import dmemPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [ADDR_W-2:0] effIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] accReg,
  output logic [PTR_W-1:0]  ptrReg
);
  localparam int BANK_DEPTH = 2 ** (ADDR_W - 1);

  logic [DATA_W-1:0] sfrBank [BANK_DEPTH];
  logic [DATA_W-1:0] ramBank [BANK_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg <= '0;
      accReg <= '0;
    end else begin
      if (strobes.wrPtr) ptrReg <= wrData[PTR_W-1:0];
      if (strobes.wrAcc) accReg <= wrData;
    end
  end

  // Special-function storage: one register per index, reset to zero.
  for (genvar i = 0; i < BANK_DEPTH; i++) begin : gSfr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       sfrBank[i] <= '0;
      else if (strobes.wrSfr && effIdx == (ADDR_W-1)'(i)) sfrBank[i] <= wrData;
    end
  end

  // General-purpose RAM: no reset.
  always_ff @(posedge clk) begin
    if (strobes.wrRam) ramBank[effIdx] <= wrData;
  end

  always_comb begin
    rdData = '0;
    unique case (strobes.sel)
      SEL_PTR: begin
        rdData = '1;
        rdData[PTR_W-1:0] = ptrReg;
      end
      SEL_ACC:  rdData = accReg;
      SEL_SFR:  rdData = sfrBank[effIdx];
      SEL_RAM:  rdData = ramBank[effIdx];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dmemFront.sv
module dmemFront
  import dmemPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = 7,
  parameter int ACC_ADDR = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] accOut,
  output logic [PTR_W-1:0]  ptrOut
);
  ctrlStrobesT       strobes;
  logic [ADDR_W-2:0] effIdx;

  dmemCtrl #(.ADDR_W(ADDR_W), .ACC_ADDR(ACC_ADDR)) ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .ptrLow  (ptrOut[ADDR_W-1:0]),
    .strobes (strobes),
    .effIdx  (effIdx)
  );

  dmemData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .effIdx  (effIdx),
    .wrData  (wrData),
    .rdData  (rdData),
    .accReg  (accOut),
    .ptrReg  (ptrOut)
  );
endmodule

// File: rtl/dmemFrontCheck.sv
module dmemFrontCheck #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = 7,
  parameter int ACC_ADDR = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] accOut,
  input logic [PTR_W-1:0]  ptrOut
);
  localparam logic [ADDR_W-1:0] DEAD_LO = ADDR_W'(2 ** (ADDR_W - 1) - 2);
  localparam logic [ADDR_W-1:0] DEAD_HI = ADDR_W'(2 ** (ADDR_W - 1) - 1);
  localparam logic [ADDR_W-1:0] ACC_A   = ADDR_W'(ACC_ADDR);

  logic nullAlias;
  assign nullAlias = (addr == '0) && (ptrOut[ADDR_W-1:0] == '0);

  a_r3_null_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    nullAlias |-> rdData == '0);

  a_r4_null_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (nullAlias && wrEn) |=> ($stable(accOut) && $stable(ptrOut)));

  a_r5_ptr_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(1)) |=> ptrOut == $past(wrData[PTR_W-1:0]));

  a_r6_ptr_top_one: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(1)) |-> (rdData[DATA_W-1] && rdData[PTR_W-1:0] == ptrOut));

  a_r7_acc_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ACC_A) |=> accOut == $past(wrData));

  a_r7_acc_read: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ACC_A) |-> rdData == accOut);

  a_r8_dead_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == DEAD_LO || addr == DEAD_HI) |-> rdData == '0);
endmodule

bind dmemFront dmemFrontCheck #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .ACC_ADDR(ACC_ADDR)
) chk (.*);

// File: tb/dmemFront_test.sv
module dmemFront_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] accOut;
  logic [6:0] ptrOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: flat byte image plus a pointer.
  logic [7:0] mImg [64];
  bit         mKnown [64];
  logic [6:0] mPtr;

  always #4 clk = ~clk;

  dmemFront uut (.*);

  function automatic int effOf(input logic [5:0] a);
    return (a == 6'h00) ? int'(mPtr[5:0]) : int'(a);
  endfunction

  function automatic bit isDead(input int e);
    return (e == 0) || (e == 30) || (e == 31);
  endfunction

  function automatic logic [7:0] modelRead(input logic [5:0] a);
    int e = effOf(a);
    if (isDead(e)) return 8'h00;
    if (e == 1) return {1'b1, mPtr};
    return mImg[e];
  endfunction

  task automatic modelWrite(input logic [5:0] a, input logic [7:0] d);
    int e = effOf(a);
    if (isDead(e)) return;
    if (e == 1) mPtr = d[6:0];
    else begin
      mImg[e] = d;
      mKnown[e] = 1;
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // One cycle: drive on the falling edge, compare before the rising edge,
  // and apply any write to the model after that edge.
  task automatic step(input string tag, input logic [5:0] a,
                      input bit we, input logic [7:0] d);
    int e;
    @(negedge clk);
    addr = a; wrEn = we; wrData = d;
    #1;
    e = effOf(a);
    if (isDead(e) || e == 1 || mKnown[e]) check(tag, rdData, modelRead(a));
    check({tag, " acc"}, accOut, mImg[5]);
    check({tag, " ptr"}, {1'b0, ptrOut}, {1'b0, mPtr});
    @(posedge clk);
    if (we) modelWrite(a, d);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mImg[i] = '0;
      mKnown[i] = (i < 32);
    end
    mPtr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R9: reset values of the pointer, accumulator and special storage
    for (int a = 1; a < 32; a++) step("R9 reset", 6'(a), 0, 8'h00);

    // R10: special storage write and read back
    for (int a = 2; a < 30; a++) if (a != 5) step("R10 sfr wr", 6'(a), 1, 8'(a * 7 + 3));
    for (int a = 2; a < 30; a++) step("R10 sfr rd", 6'(a), 0, 8'h00);

    // R1: fill the RAM, then read it back in reverse order
    for (int a = 32; a < 64; a++) step("R1 ram wr", 6'(a), 1, 8'(a ^ 8'hA5));
    for (int a = 63; a >= 32; a--) step("R1 ram rd", 6'(a), 0, 8'h00);
    step("R1 wr", 6'h27, 1, 8'h5C);
    step("R1 rd next", 6'h27, 0, 8'h00);

    // R7: accumulator at 05H
    step("R7 acc wr", 6'h05, 1, 8'hC3);
    step("R7 acc rd", 6'h05, 0, 8'h00);

    // R5/R6: only 7 bits kept; bit 7 reads as one
    step("R5 ptr wr", 6'h01, 1, 8'hFF);
    step("R6 ptr rd", 6'h01, 0, 8'h00);
    step("R5 ptr wr2", 6'h01, 1, 8'h12);
    step("R6 ptr rd2", 6'h01, 0, 8'h00);

    // R2: aliased access to RAM, accumulator and special storage
    step("R5 ptr", 6'h01, 1, 8'h3F);
    step("R2 ind rd ram", 6'h00, 0, 8'h00);
    step("R2 ind wr ram", 6'h00, 1, 8'h9E);
    step("R2 direct view", 6'h3F, 0, 8'h00);
    step("R5 ptr", 6'h01, 1, 8'h45);
    step("R2 ind wr acc", 6'h00, 1, 8'h77);
    step("R2 acc seen", 6'h05, 0, 8'h00);
    step("R5 ptr", 6'h01, 1, 8'h0C);
    step("R2 ind wr sfr", 6'h00, 1, 8'h3B);
    step("R2 sfr seen", 6'h0C, 0, 8'h00);

    // R2/R5: alias onto the pointer itself
    step("R5 ptr", 6'h01, 1, 8'h01);
    step("R2 ind ptr rd", 6'h00, 0, 8'h00);
    step("R5 ind ptr wr", 6'h00, 1, 8'hA8);
    step("R5 ptr after", 6'h01, 0, 8'h00);

    // R3/R4: pointer with zero address bits (bit 6 clear and set)
    step("R5 ptr", 6'h01, 1, 8'h00);
    step("R3 null rd", 6'h00, 0, 8'h00);
    step("R4 null wr", 6'h00, 1, 8'hEE);
    step("R4 acc kept", 6'h05, 0, 8'h00);
    step("R4 ptr kept", 6'h01, 0, 8'h00);
    step("R5 ptr", 6'h01, 1, 8'h40);
    step("R3 null rd b6", 6'h00, 0, 8'h00);
    step("R4 null wr b6", 6'h00, 1, 8'h11);
    step("R4 ptr kept b6", 6'h01, 0, 8'h00);
    for (int a = 2; a < 64; a++) step("R4 storage kept", 6'(a), 0, 8'h00);

    // R8: dead locations, direct and aliased
    step("R8 wr 1E", 6'h1E, 1, 8'hFF);
    step("R8 rd 1E", 6'h1E, 0, 8'h00);
    step("R8 wr 1F", 6'h1F, 1, 8'h81);
    step("R8 rd 1F", 6'h1F, 0, 8'h00);
    step("R5 ptr", 6'h01, 1, 8'h1F);
    step("R8 ind wr", 6'h00, 1, 8'h66);
    step("R8 ind rd", 6'h00, 0, 8'h00);

    // R1/R2/R10: mixed traffic against the model
    for (int i = 0; i < 2000; i++)
      step("R2 mixed", 6'($urandom_range(0, 63)), bit'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule